// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block is a small fully associative translation lookaside store. Each entry maps a logical page number and a privilege flag to a physical page number and a set of page attributes: cache mode, two user-defined attribute bits, a supervisor-only bit, a write-protect bit, a modified bit and a global bit. A lookup presents a logical address, a supervisor flag and a read/write flag. In the same cycle the block returns a hit or a walk request, the translated physical address and the attributes of the matching entry.

On a walk request an external table walker, which is not part of this block, later installs a descriptor through the install port. Flush commands clear all entries, all non-global entries, or the entries that match one page and privilege mode. The page-matching flush can also be told to spare global entries. A runtime input selects 4 KB or 8 KB pages. Software must flush all entries before it changes the page size.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid: every lookup gives hit_o=0 and walk_req_o=1.
- R2: A lookup hits only when a valid entry has a matching logical page and a matching mode bit (1 = supervisor, 0 = user). For every lookup, walk_req_o is the inverse of hit_o.
- R3: With 4 KB pages (pg8k_i=0) the compare uses address bits 31..12, and pa_o = {stored physical page, lk_addr_i[11:0]}.
- R4: With 8 KB pages (pg8k_i=1) the compare uses address bits 31..13 and ignores bit 0 of the stored page, and pa_o = {stored physical page[19:1], lk_addr_i[12:0]}.
- R5: On a hit, the outputs give the stored attributes. cmode_o is encoded as 00 cachable write-through, 01 cachable copyback, 10 noncachable serialized, 11 noncachable.
- R6: A write lookup that matches an entry whose modified bit is clear gives hit_o=0 and walk_req_o=1. A read of the same entry hits. Once the entry has been reinstalled with the modified bit set, the write hits.
- R7: An install whose page and mode match a valid entry overwrites that entry in place and uses up no slot. Any other install goes into round-robin slots, so with all slots in use the install that has been resident longest is evicted.
- R8: The flush-all command (fl_op_i=0) invalidates every entry.
- R9: The non-global flush (fl_op_i=1) invalidates every entry with the global bit clear and leaves global entries valid.
- R10: The page flush (fl_op_i=2) invalidates the entry that matches fl_vpn_i and fl_sup_i. The page flush that spares global entries (fl_op_i=3) does the same only for an entry whose global bit is clear. Entries with another mode or page are kept.
- R11: When a flush and an install arrive in the same cycle, the flush is carried out and the install is dropped.
- R12: A lookup resolves in the cycle it is presented. An installed or flushed entry affects lookups from the cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pg8k_i | input | 1 | Page size select: 0 = 4 KB, 1 = 8 KB |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | VA_W | Logical address |
| lk_sup_i | input | 1 | Requesting mode: 1 = supervisor |
| lk_write_i | input | 1 | Lookup is a write |
| hit_o | output | 1 | Translation available |
| walk_req_o | output | 1 | Table walk needed |
| pa_o | output | PA_W | Physical address |
| cmode_o | output | 2 | Cache mode of the hit entry |
| uattr_o | output | 2 | User attribute bits |
| sonly_o | output | 1 | Supervisor-only page |
| wprot_o | output | 1 | Write-protected page |
| modif_o | output | 1 | Modified bit |
| glob_o | output | 1 | Global bit |
| ins_valid_i | input | 1 | Install a descriptor |
| ins_vpn_i | input | VA_W-12 | Logical page of the descriptor |
| ins_sup_i | input | 1 | Mode of the descriptor |
| ins_ppn_i | input | PA_W-12 | Physical page |
| ins_cmode_i | input | 2 | Cache mode |
| ins_uattr_i | input | 2 | User attribute bits |
| ins_sonly_i | input | 1 | Supervisor-only bit |
| ins_wprot_i | input | 1 | Write-protect bit |
| ins_modif_i | input | 1 | Modified bit |
| ins_glob_i | input | 1 | Global bit |
| fl_valid_i | input | 1 | Flush command |
| fl_op_i | input | 2 | 0 all, 1 non-global, 2 page, 3 page non-global |
| fl_vpn_i | input | VA_W-12 | Page selector for page flushes |
| fl_sup_i | input | 1 | Mode selector for page flushes |

## Verification
The bench builds the block with its default values: 16 entries and 32-bit logical and physical addresses. With 16 entries the bench can fill every slot and make the round-robin pointer wrap with 17 installs. It can also show that an in-place overwrite uses up no slot. Both page sizes are exercised at run time through pg8k_i, including a case where the ignored low tag bit and address bit 12 differ.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_NONGLOB = 2'd1,
    FL_PAGE    = 2'd2,
    FL_PAGE_NG = 2'd3
  } flush_op_e;

  typedef struct packed {
    logic [1:0] cmode;
    logic [1:0] uattr;
    logic       sonly;
    logic       wprot;
    logic       modif;
    logic       glob;
  } attr_t;

  function automatic logic kill_f(logic [1:0] op, logic glob, logic page_hit);
    case (flush_op_e'(op))
      FL_ALL:     kill_f = 1'b1;
      FL_NONGLOB: kill_f = ~glob;
      FL_PAGE:    kill_f = page_hit;
      default:    kill_f = page_hit & ~glob;
    endcase
  endfunction
endpackage

// File: rtl/xlat_tag_cmp.sv
module xlat_tag_cmp #(
  parameter int VPN_W = 20
) (
  input  logic             valid_i,
  input  logic [VPN_W-1:0] tag_vpn_i,
  input  logic             tag_sup_i,
  input  logic [VPN_W-1:0] key_vpn_i,
  input  logic             key_sup_i,
  input  logic             pg8k_i,
  output logic             hit_o
);
  logic [VPN_W-1:0] mask;
  // 8 KB pages: lowest stored page bit takes no part in the compare
  assign mask  = {{(VPN_W-1){1'b1}}, ~pg8k_i};
  assign hit_o = valid_i && (tag_sup_i == key_sup_i)
                 && (((tag_vpn_i ^ key_vpn_i) & mask) == '0);
endmodule

// File: rtl/xlat_rr_ptr.sv
module xlat_rr_ptr #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + 1'b1)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o)); // R7
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  localparam int VPN_W  = VA_W - 12,
  localparam int PPN_W  = PA_W - 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pg8k_i,
  input  logic             lk_valid_i,
  input  logic [VA_W-1:0]  lk_addr_i,
  input  logic             lk_sup_i,
  input  logic             lk_write_i,
  output logic             hit_o,
  output logic             walk_req_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [1:0]       cmode_o,
  output logic [1:0]       uattr_o,
  output logic             sonly_o,
  output logic             wprot_o,
  output logic             modif_o,
  output logic             glob_o,
  input  logic             ins_valid_i,
  input  logic [VPN_W-1:0] ins_vpn_i,
  input  logic             ins_sup_i,
  input  logic [PPN_W-1:0] ins_ppn_i,
  input  logic [1:0]       ins_cmode_i,
  input  logic [1:0]       ins_uattr_i,
  input  logic             ins_sonly_i,
  input  logic             ins_wprot_i,
  input  logic             ins_modif_i,
  input  logic             ins_glob_i,
  input  logic             fl_valid_i,
  input  logic [1:0]       fl_op_i,
  input  logic [VPN_W-1:0] fl_vpn_i,
  input  logic             fl_sup_i
);
  logic [ENTRIES-1:0] vld_q, sup_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  attr_t              attr_q [ENTRIES];

  logic [ENTRIES-1:0] lk_hit, ins_hit, fl_hit, fl_kill, ins_sel;
  logic [IDX_W-1:0]   rr_ptr;
  logic               ins_any, rr_adv;
  attr_t              ins_attr;

  assign ins_attr = '{cmode: ins_cmode_i, uattr: ins_uattr_i, sonly: ins_sonly_i,
                      wprot: ins_wprot_i, modif: ins_modif_i, glob: ins_glob_i};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xlat_tag_cmp #(.VPN_W(VPN_W)) u_cmp_lk (
      .valid_i(vld_q[g]), .tag_vpn_i(vpn_q[g]), .tag_sup_i(sup_q[g]),
      .key_vpn_i(lk_addr_i[VA_W-1:12]), .key_sup_i(lk_sup_i),
      .pg8k_i(pg8k_i), .hit_o(lk_hit[g]));
    xlat_tag_cmp #(.VPN_W(VPN_W)) u_cmp_ins (
      .valid_i(vld_q[g]), .tag_vpn_i(vpn_q[g]), .tag_sup_i(sup_q[g]),
      .key_vpn_i(ins_vpn_i), .key_sup_i(ins_sup_i),
      .pg8k_i(pg8k_i), .hit_o(ins_hit[g]));
    xlat_tag_cmp #(.VPN_W(VPN_W)) u_cmp_fl (
      .valid_i(vld_q[g]), .tag_vpn_i(vpn_q[g]), .tag_sup_i(sup_q[g]),
      .key_vpn_i(fl_vpn_i), .key_sup_i(fl_sup_i),
      .pg8k_i(pg8k_i), .hit_o(fl_hit[g]));

    assign fl_kill[g] = kill_f(fl_op_i, attr_q[g].glob, fl_hit[g]);

    // ops with bit 0 set spare global entries
    AST_GLOB_SURVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fl_valid_i && fl_op_i[0] && vld_q[g] && attr_q[g].glob) |=> vld_q[g]); // R9
    AST_INSTALL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ins_valid_i && !fl_valid_i && ins_sel[g])
        |=> (vld_q[g] && vpn_q[g] == $past(ins_vpn_i) && sup_q[g] == $past(ins_sup_i))); // R7
  end

  // in-place overwrite of a matching entry, else round-robin victim
  assign ins_any = |ins_hit;
  assign ins_sel = ins_any ? ins_hit : (ENTRIES'(1) << rr_ptr);
  assign rr_adv  = ins_valid_i && !fl_valid_i && !ins_any;

  xlat_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rr_adv), .ptr_o(rr_ptr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      sup_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        attr_q[i] <= '0;
      end
    end else if (fl_valid_i) begin
      vld_q <= vld_q & ~fl_kill;
    end else if (ins_valid_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ins_sel[i]) begin
          vld_q[i]  <= 1'b1;
          sup_q[i]  <= ins_sup_i;
          vpn_q[i]  <= ins_vpn_i;
          ppn_q[i]  <= ins_ppn_i;
          attr_q[i] <= ins_attr;
        end
      end
    end
  end

  // lookup read-out: one-hot OR select
  logic [PPN_W-1:0] sel_ppn;
  logic [7:0]       sel_bits;
  attr_t            sel_attr;
  logic             hit_raw;

  always_comb begin
    sel_ppn  = '0;
    sel_bits = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit[i]) begin
        sel_ppn  = sel_ppn | ppn_q[i];
        sel_bits = sel_bits | attr_q[i];
      end
    end
  end

  assign sel_attr   = attr_t'(sel_bits);
  assign hit_raw    = lk_valid_i && (|lk_hit);
  // clean page written: force miss so the walker can set the modified bit
  assign hit_o      = hit_raw && !(lk_write_i && !sel_attr.modif);
  assign walk_req_o = lk_valid_i && !hit_o;
  assign pa_o       = pg8k_i ? {sel_ppn[PPN_W-1:1], lk_addr_i[12:0]}
                             : {sel_ppn, lk_addr_i[11:0]};
  assign cmode_o    = sel_attr.cmode;
  assign uattr_o    = sel_attr.uattr;
  assign sonly_o    = sel_attr.sonly;
  assign wprot_o    = sel_attr.wprot;
  assign modif_o    = sel_attr.modif;
  assign glob_o     = sel_attr.glob;

  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> $onehot0(lk_hit)); // R2
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_valid_i && fl_op_i == FL_ALL) |=> (vld_q == '0)); // R8
  AST_WRITE_NEEDS_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && lk_write_i) |-> modif_o); // R6
  AST_FLUSH_BLOCKS_INSTALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_valid_i && ins_valid_i) |=> ((vld_q & ~$past(vld_q)) == '0)); // R11
  AST_HIT_WALK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && walk_req_o)); // R2
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        pg8k = 0, lk_valid = 0, lk_sup = 0, lk_write = 0;
  logic [31:0] lk_addr = '0;
  logic        hit, walk, sonly, wprot, modif, glob;
  logic [31:0] pa;
  logic [1:0]  cmode, uattr;
  logic        ins_valid = 0, ins_sup = 0;
  logic [19:0] ins_vpn = '0, ins_ppn = '0;
  logic [7:0]  ins_at = '0;
  logic        fl_valid = 0, fl_sup = 0;
  logic [1:0]  fl_op = '0;
  logic [19:0] fl_vpn = '0;

  xlat_cache #(.ENTRIES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pg8k_i(pg8k),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_sup_i(lk_sup), .lk_write_i(lk_write),
    .hit_o(hit), .walk_req_o(walk), .pa_o(pa), .cmode_o(cmode), .uattr_o(uattr),
    .sonly_o(sonly), .wprot_o(wprot), .modif_o(modif), .glob_o(glob),
    .ins_valid_i(ins_valid), .ins_vpn_i(ins_vpn), .ins_sup_i(ins_sup), .ins_ppn_i(ins_ppn),
    .ins_cmode_i(ins_at[7:6]), .ins_uattr_i(ins_at[5:4]), .ins_sonly_i(ins_at[3]),
    .ins_wprot_i(ins_at[2]), .ins_modif_i(ins_at[1]), .ins_glob_i(ins_at[0]),
    .fl_valid_i(fl_valid), .fl_op_i(fl_op), .fl_vpn_i(fl_vpn), .fl_sup_i(fl_sup));

  typedef struct {
    bit          hit;
    logic [31:0] pa;
    logic [7:0]  at;
    int          rq;
  } exp_t;

  exp_t sb[$];
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  function automatic logic [31:0] pa_of(logic [19:0] ppn, logic [31:0] a, logic big);
    return big ? {ppn[19:1], a[12:0]} : {ppn, a[11:0]};
  endfunction

  // monitor: compare design output against scoreboard head
  always @(negedge clk) begin
    exp_t e;
    if (lk_valid) begin
      n_vec++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R0 scoreboard empty on lookup");
      end else begin
        e = sb.pop_front();
        if (hit !== e.hit || walk !== !e.hit) begin
          n_bad++;
          $display("FAIL R%0d addr=%h hit/walk act=%b%b exp=%b%b", e.rq, lk_addr, hit, walk, e.hit, !e.hit);
        end else if (e.hit && pa !== e.pa) begin
          n_bad++;
          $display("FAIL R%0d addr=%h pa act=%h exp=%h", e.rq, lk_addr, pa, e.pa);
        end else if (e.hit && {cmode, uattr, sonly, wprot, modif, glob} !== e.at) begin
          n_bad++;
          $display("FAIL R%0d addr=%h attr act=%b exp=%b", e.rq, lk_addr,
                   {cmode, uattr, sonly, wprot, modif, glob}, e.at);
        end
      end
    end
  end

  task automatic look(input logic [31:0] a, input bit s, input bit w, input bit eh,
                      input logic [19:0] eppn, input logic [7:0] eat, input int rq);
    exp_t e;
    lk_addr = a; lk_sup = s; lk_write = w; lk_valid = 1;
    e.hit = eh; e.pa = pa_of(eppn, a, pg8k); e.at = eat; e.rq = rq;
    sb.push_back(e);
    @(posedge clk); #1;
    lk_valid = 0; lk_write = 0;
  endtask

  task automatic inst(input logic [19:0] v, input bit s, input logic [19:0] p, input logic [7:0] at);
    ins_vpn = v; ins_sup = s; ins_ppn = p; ins_at = at; ins_valid = 1;
    @(posedge clk); #1;
    ins_valid = 0;
  endtask

  task automatic flush(input logic [1:0] op, input logic [19:0] v, input bit s);
    fl_op = op; fl_vpn = v; fl_sup = s; fl_valid = 1;
    @(posedge clk); #1;
    fl_valid = 0;
  endtask

  task automatic flush_and_inst(input logic [1:0] op, input logic [19:0] v, input logic [19:0] p);
    fl_op = op; fl_vpn = v; fl_sup = 0; fl_valid = 1;
    ins_vpn = v; ins_sup = 0; ins_ppn = p; ins_at = 8'h02; ins_valid = 1;
    @(posedge clk); #1;
    fl_valid = 0; ins_valid = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R0 watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1: empty after reset
    look(32'h1234_5678, 0, 0, 0, '0, '0, 1);
    look(32'h1234_5678, 1, 0, 0, '0, '0, 1);

    // R3 R5 R12: user page, copyback, attrs {cm,ua,so,wp,md,gl}
    inst(20'h12345, 0, 20'hABCDE, 8'b01_10_0_1_1_0);
    look(32'h1234_5678, 0, 0, 1, 20'hABCDE, 8'b01_10_0_1_1_0, 3);
    look(32'h1234_5678, 1, 0, 0, '0, '0, 2);           // R2 mode mismatch
    look(32'h1234_4678, 0, 0, 0, '0, '0, 3);           // R3 bit 12 differs

    // R5 R6: supervisor global page, noncachable serialized, clean
    inst(20'h00100, 1, 20'h00200, 8'b10_01_1_0_0_1);
    look(32'h0010_0ABC, 1, 0, 1, 20'h00200, 8'b10_01_1_0_0_1, 5);
    look(32'h0010_0ABC, 1, 1, 0, '0, '0, 6);           // R6 clean write misses
    inst(20'h00100, 1, 20'h00200, 8'b10_01_1_0_1_1);
    look(32'h0010_0ABC, 1, 1, 1, 20'h00200, 8'b10_01_1_0_1_1, 6);

    // R9: non-global flush
    flush(2'd1, '0, 0);
    look(32'h1234_5678, 0, 0, 0, '0, '0, 9);
    look(32'h0010_0004, 1, 0, 1, 20'h00200, 8'b10_01_1_0_1_1, 9);

    // R10: page flushes
    inst(20'h55555, 0, 20'h0AAAA, 8'b11_00_0_0_1_1);
    inst(20'h66666, 0, 20'h0BBBB, 8'b00_11_0_0_1_0);
    flush(2'd3, 20'h55555, 0);
    look(32'h5555_5010, 0, 0, 1, 20'h0AAAA, 8'b11_00_0_0_1_1, 10);
    flush(2'd2, 20'h55555, 0);
    look(32'h5555_5010, 0, 0, 0, '0, '0, 10);
    flush(2'd3, 20'h66666, 1);
    look(32'h6666_6020, 0, 0, 1, 20'h0BBBB, 8'b00_11_0_0_1_0, 10);
    flush(2'd2, 20'h66666, 0);
    look(32'h6666_6020, 0, 0, 0, '0, '0, 10);

    // R8: flush all
    flush(2'd0, '0, 0);
    look(32'h0010_0ABC, 1, 0, 0, '0, '0, 8);

    // R11: flush wins over simultaneous install
    flush_and_inst(2'd0, 20'h77777, 20'h01111);
    look(32'h7777_7000, 0, 0, 0, '0, '0, 11);

    // R7: round-robin eviction of the oldest install
    for (int i = 0; i <= N; i++) inst(20'h80000 + 20'(i), 0, 20'h40000 + 20'(i), 8'h02);
    look(32'h8000_0000, 0, 0, 0, '0, '0, 7);
    for (int i = 1; i <= N; i++)
      look({20'h80000 + 20'(i), 12'h0F0}, 0, 0, 1, 20'h40000 + 20'(i), 8'h02, 7);

    // R7: in-place overwrite uses no slot
    flush(2'd0, '0, 0);
    inst(20'h90000, 0, 20'h11111, 8'h02);
    inst(20'h90000, 0, 20'h22222, 8'h42);
    for (int i = 1; i < N; i++) inst(20'h90000 + 20'(i), 0, 20'h30000 + 20'(i), 8'h02);
    look(32'h9000_0ABC, 0, 0, 1, 20'h22222, 8'h42, 7);
    look({20'h90000 + 20'(N-1), 12'h004}, 0, 0, 1, 20'h30000 + 20'(N-1), 8'h02, 7);
    inst(20'h9FFFF, 0, 20'h33333, 8'h02);
    look(32'h9000_0ABC, 0, 0, 0, '0, '0, 7);

    // R4: 8 KB pages, stored bit 0 ignored
    flush(2'd0, '0, 0);
    pg8k = 1;
    inst(20'h2468B, 0, 20'h13579, 8'h02);
    look(32'h2468_AABC, 0, 0, 1, 20'h13579, 8'h02, 4);
    look(32'h2468_B123, 0, 0, 1, 20'h13579, 8'h02, 4);
    look(32'h2468_C123, 0, 0, 0, '0, '0, 4);
    flush(2'd0, '0, 0);
    pg8k = 0;
    look(32'h2468_B123, 0, 0, 0, '0, '0, 4);

    @(posedge clk); #1;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R12 %0d expected results never produced (exp 0)", sb.size());
    end
    summary();
  end
endmodule